// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits beside the execute stage of a small soft processor core and decides, one request at a time, whether the core enters a handler. Four kinds of event reach it: a hardware exception, a memory-management fault, an external interrupt and a hardware break. When it accepts one, it commits the whole handler entry in a single registered update. That update covers the redirected program counter, the return-address register write, the machine status word, the exception syndrome, the faulting address and the saved branch target. It also issues a one-cycle pulse that tells the pipeline to drop its delay-slot and immediate-prefix state and to cancel any load-reserved reservation.

Each event kind has its own vector offset from a configurable base, its own return register and its own rule for correcting the return address. Memory faults may strike an instruction that sits in a branch delay slot. In that case the syndrome records the fact, the branch target is preserved, and the return address is moved back to the branch (and to its prefix, if it had one) so that the whole sequence runs again. The core's current status word is an input. The block writes back the updated copy, in which the translation-enable and user-mode bits have been moved into their shadow positions.

A memory fault that arrives in the cycle right after a memory fault entry is not entered again. Instead it raises a sticky double-fault output.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The new PC is `VEC_BASE` plus an offset: 0x10 for an interrupt, 0x18 for a break, and 0x20 for a hardware exception or a memory fault. Event kind codes on `req_kind` are 0 for a hardware exception, 1 for a memory fault, 2 for an interrupt and 3 for a break.
- R2: On every entry `rf_we` pulses for one cycle. `rf_waddr` is 14 for an interrupt, 16 for a break and 17 for a hardware exception or a memory fault. For an interrupt or a break, `rf_wdata` is the current PC.
- R3: Status bit positions are: interrupt enable 1, break in progress 3, exception in progress 9, user mode 11, user-mode shadow 12, translation enable 13, translation shadow 14. On every entry, bits 11 and 13 are copied into bits 12 and 14 respectively, and then bits 11 and 13 are cleared.
- R4: An interrupt entry clears bit 1. A hardware exception or memory fault entry sets bit 9. A break entry sets bit 3. All other status bits pass through unchanged.
- R5: An interrupt is accepted only if all of the following hold: bit 1 is set, bits 3 and 9 are clear, and neither `in_dslot` nor `in_imm` is set. Otherwise it produces no entry and changes no output.
- R6: A hardware exception returns to PC+4. Its syndrome is `hw_cause` zero-extended, and `fault_addr` is latched into `ear_out`.
- R7: For a hardware exception or memory fault taken in a delay slot, syndrome bit 12 is set and `btr_out` takes `br_target`. Outside a delay slot, bit 12 is clear and `btr_out` is held.
- R8: A memory fault returns to PC, adjusted as follows. In a delay slot, it returns to PC-4, or to PC-8 when `br_was_imm` is set. Outside a delay slot with `in_imm` set, it returns to PC-4.
- R9: The memory fault syndrome low bits depend on `fault_miss` and `acc_kind`. Fetch protection gives 17, data protection 16, fetch miss 19 and data miss 18. `acc_kind` is 0 for fetch, 1 for load and 2 for store. Bit 10 is set for a store, and `fault_addr` is latched into `ear_out`.
- R10: With `EXC_EN` = 0, hardware exception requests produce no entry and change no output.
- R11: `flush_flags` and `resv_clr` pulse for exactly the cycle of each entry.
- R12: A memory fault request in the cycle right after an accepted memory fault entry is not entered. It sets `double_fault`, which then stays set until reset.
- R13: Every output register changes in the single cycle after the accepted request. Without an accepted request, no output register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Event request present this cycle |
| req_kind | input | 2 | Event kind code |
| cur_pc | input | XLEN | PC of the affected instruction |
| br_target | input | XLEN | Target of the pending branch |
| in_dslot | input | 1 | Instruction is in a delay slot |
| in_imm | input | 1 | Instruction carries an immediate prefix |
| br_was_imm | input | 1 | The pending branch had an immediate prefix |
| status_in | input | XLEN | Current machine status word |
| acc_kind | input | 2 | Access type of the faulting memory operation |
| fault_miss | input | 1 | Memory fault was a translation miss (else protection) |
| fault_addr | input | XLEN | Faulting address |
| hw_cause | input | CAUSE_W | Cause code of a hardware exception |
| entry_valid | output | 1 | A handler entry was committed |
| new_pc | output | XLEN | Handler address |
| rf_we | output | 1 | Return-address register write enable |
| rf_waddr | output | 5 | Return-address register index |
| rf_wdata | output | XLEN | Return address |
| status_out | output | XLEN | Updated status word |
| esr_out | output | XLEN | Exception syndrome |
| ear_out | output | XLEN | Exception address |
| btr_out | output | XLEN | Saved branch target |
| flush_flags | output | 1 | Clear delay-slot and prefix flags |
| resv_clr | output | 1 | Invalidate load reservation |
| double_fault | output | 1 | Sticky nested memory fault error |

## Verification
A wrong acceptance decision shows up one cycle after the request, as an `entry_valid` pulse that should not be there, or that is missing. A wrong correction path shows up in that same cycle as a `rf_wdata` value off by a multiple of four, or a syndrome with bit 10 or bit 12 wrong. A wrong internal fault-busy flag shows up only on a back-to-back memory fault, as a re-entry instead of `double_fault` rising. Held registers drifting between entries show up in the idle cycles that follow each scenario.

// File: rtl/exc_entry_pkg.sv
// Shared encodings for the exception entry controller.
// Assumes the status word and syndrome are at least 15 bits wide.
package exc_entry_pkg;
    typedef enum logic [1:0] {
        EV_HWEXC = 2'd0,
        EV_MMU   = 2'd1,
        EV_IRQ   = 2'd2,
        EV_BREAK = 2'd3
    } ev_kind_t;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    localparam int ST_IE  = 1;
    localparam int ST_BIP = 3;
    localparam int ST_EIP = 9;
    localparam int ST_UM  = 11;
    localparam int ST_UMS = 12;
    localparam int ST_VM  = 13;
    localparam int ST_VMS = 14;

    localparam int SYN_STORE_BIT = 10;
    localparam int SYN_DSLOT_BIT = 12;

    localparam logic [4:0] RA_IRQ = 5'd14;
    localparam logic [4:0] RA_BRK = 5'd16;
    localparam logic [4:0] RA_EXC = 5'd17;

    localparam logic [7:0] OFS_IRQ = 8'h10;
    localparam logic [7:0] OFS_BRK = 8'h18;
    localparam logic [7:0] OFS_EXC = 8'h20;
endpackage

// File: rtl/exc_accept.sv
// Acceptance decision for one event request.
// Assumes status bits arrive already extracted.
// A memory fault during the busy cycle is diverted to the double-fault path.
module exc_accept
    import exc_entry_pkg::*;
#(
    parameter bit EXC_EN = 1'b1
) (
    input  logic     req_valid,
    input  ev_kind_t kind,
    input  logic     st_ie,
    input  logic     st_bip,
    input  logic     st_eip,
    input  logic     in_dslot,
    input  logic     in_imm,
    input  logic     mmu_busy,
    output logic     accept,
    output logic     dfault_hit
);
    logic hw_ok;

    // Configuration gate for hardware exceptions.
    generate
        if (EXC_EN) begin : g_exc_on
            assign hw_ok = 1'b1;
        end else begin : g_exc_off
            assign hw_ok = 1'b0;
        end
    endgenerate

    // Per-kind acceptance conditions.
    always_comb begin
        accept     = 1'b0;
        dfault_hit = 1'b0;
        if (req_valid) begin
            unique case (kind)
                EV_HWEXC: accept = hw_ok;
                EV_MMU: begin
                    accept     = !mmu_busy;
                    dfault_hit = mmu_busy;
                end
                EV_IRQ:   accept = st_ie && !st_bip && !st_eip && !in_dslot && !in_imm;
                EV_BREAK: accept = 1'b1;
                default:  accept = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/exc_target.sv
// Handler address, return register index and corrected return address.
// Assumes XLEN >= 8 so the vector offsets fit.
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  ev_kind_t        kind,
    input  logic [XLEN-1:0] pc,
    input  logic            in_dslot,
    input  logic            in_imm,
    input  logic            br_was_imm,
    output logic [XLEN-1:0] vec_pc,
    output logic [4:0]      ra_idx,
    output logic [XLEN-1:0] ra_val
);
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    logic [XLEN-1:0] mmu_back;

    // Distance the memory-fault return address moves back.
    always_comb begin
        if (in_dslot)
            mmu_back = br_was_imm ? (WORD + WORD) : WORD;
        else if (in_imm)
            mmu_back = WORD;
        else
            mmu_back = '0;
    end

    // Vector, register and return value per kind.
    always_comb begin
        unique case (kind)
            EV_IRQ: begin
                vec_pc = VEC_BASE + XLEN'(OFS_IRQ);
                ra_idx = RA_IRQ;
                ra_val = pc;
            end
            EV_BREAK: begin
                vec_pc = VEC_BASE + XLEN'(OFS_BRK);
                ra_idx = RA_BRK;
                ra_val = pc;
            end
            EV_MMU: begin
                vec_pc = VEC_BASE + XLEN'(OFS_EXC);
                ra_idx = RA_EXC;
                ra_val = pc - mmu_back;
            end
            default: begin
                vec_pc = VEC_BASE + XLEN'(OFS_EXC);
                ra_idx = RA_EXC;
                ra_val = pc + WORD;
            end
        endcase
    end
endmodule

// File: rtl/exc_state_upd.sv
// Next values of status, syndrome, address and branch-target registers.
// Assumes the previous register values are fed back from the top.
module exc_state_upd
    import exc_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  ev_kind_t           kind,
    input  logic [XLEN-1:0]    status_in,
    input  logic [XLEN-1:0]    esr_prev,
    input  logic [XLEN-1:0]    ear_prev,
    input  logic [XLEN-1:0]    btr_prev,
    input  logic [XLEN-1:0]    br_target,
    input  logic [XLEN-1:0]    fault_addr,
    input  logic               in_dslot,
    input  acc_kind_t          acc,
    input  logic               fault_miss,
    input  logic [CAUSE_W-1:0] hw_cause,
    output logic [XLEN-1:0]    status_nxt,
    output logic [XLEN-1:0]    esr_nxt,
    output logic [XLEN-1:0]    ear_nxt,
    output logic [XLEN-1:0]    btr_nxt
);
    logic [XLEN-1:0] st_shift;
    logic [4:0]      mmu_code;
    logic            is_fault;

    assign is_fault = (kind == EV_HWEXC) || (kind == EV_MMU);

    // Move mode bits into their shadows, then set per-kind flags.
    always_comb begin
        st_shift            = status_in;
        st_shift[ST_UMS]    = status_in[ST_UM];
        st_shift[ST_VMS]    = status_in[ST_VM];
        st_shift[ST_UM]     = 1'b0;
        st_shift[ST_VM]     = 1'b0;
        status_nxt          = st_shift;
        unique case (kind)
            EV_IRQ:   status_nxt[ST_IE]  = 1'b0;
            EV_BREAK: status_nxt[ST_BIP] = 1'b1;
            default:  status_nxt[ST_EIP] = 1'b1;
        endcase
    end

    // Memory fault syndrome code from fetch/data and miss/protection.
    always_comb begin
        mmu_code = 5'd16;
        mmu_code[0] = (acc == ACC_FETCH);
        mmu_code[1] = fault_miss;
    end

    // Syndrome, address and saved branch target.
    always_comb begin
        esr_nxt = esr_prev;
        ear_nxt = ear_prev;
        btr_nxt = btr_prev;
        if (is_fault) begin
            ear_nxt = fault_addr;
            if (kind == EV_MMU) begin
                esr_nxt = XLEN'(mmu_code);
                esr_nxt[SYN_STORE_BIT] = (acc == ACC_STORE);
            end else begin
                esr_nxt = XLEN'(hw_cause);
            end
            esr_nxt[SYN_DSLOT_BIT] = in_dslot;
            if (in_dslot)
                btr_nxt = br_target;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Top of the exception entry controller: registers every entry effect
// in one cycle and keeps the sticky double-fault flag.
// Assumes requests are held by the pipeline only as long as it wants them.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              CAUSE_W  = 5,
    parameter logic [XLEN-1:0] VEC_BASE = '0,
    parameter bit              EXC_EN   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    br_target,
    input  logic               in_dslot,
    input  logic               in_imm,
    input  logic               br_was_imm,
    input  logic [XLEN-1:0]    status_in,
    input  logic [1:0]         acc_kind,
    input  logic               fault_miss,
    input  logic [XLEN-1:0]    fault_addr,
    input  logic [CAUSE_W-1:0] hw_cause,
    output logic               entry_valid,
    output logic [XLEN-1:0]    new_pc,
    output logic               rf_we,
    output logic [4:0]         rf_waddr,
    output logic [XLEN-1:0]    rf_wdata,
    output logic [XLEN-1:0]    status_out,
    output logic [XLEN-1:0]    esr_out,
    output logic [XLEN-1:0]    ear_out,
    output logic [XLEN-1:0]    btr_out,
    output logic               flush_flags,
    output logic               resv_clr,
    output logic               double_fault
);
    ev_kind_t        kind;
    logic            accept, dfault_hit, mmu_busy;
    logic [XLEN-1:0] vec_pc, ra_val, status_nxt, esr_nxt, ear_nxt, btr_nxt;
    logic [4:0]      ra_idx;

    assign kind = ev_kind_t'(req_kind);

    exc_accept #(.EXC_EN(EXC_EN)) u_accept (
        .req_valid (req_valid),
        .kind      (kind),
        .st_ie     (status_in[ST_IE]),
        .st_bip    (status_in[ST_BIP]),
        .st_eip    (status_in[ST_EIP]),
        .in_dslot  (in_dslot),
        .in_imm    (in_imm),
        .mmu_busy  (mmu_busy),
        .accept    (accept),
        .dfault_hit(dfault_hit)
    );

    exc_target #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_target (
        .kind      (kind),
        .pc        (cur_pc),
        .in_dslot  (in_dslot),
        .in_imm    (in_imm),
        .br_was_imm(br_was_imm),
        .vec_pc    (vec_pc),
        .ra_idx    (ra_idx),
        .ra_val    (ra_val)
    );

    exc_state_upd #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_state (
        .kind      (kind),
        .status_in (status_in),
        .esr_prev  (esr_out),
        .ear_prev  (ear_out),
        .btr_prev  (btr_out),
        .br_target (br_target),
        .fault_addr(fault_addr),
        .in_dslot  (in_dslot),
        .acc       (acc_kind_t'(acc_kind)),
        .fault_miss(fault_miss),
        .hw_cause  (hw_cause),
        .status_nxt(status_nxt),
        .esr_nxt   (esr_nxt),
        .ear_nxt   (ear_nxt),
        .btr_nxt   (btr_nxt)
    );

    // Entry pulses and the one-cycle memory-fault busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_valid  <= 1'b0;
            rf_we        <= 1'b0;
            flush_flags  <= 1'b0;
            resv_clr     <= 1'b0;
            mmu_busy     <= 1'b0;
        end else begin
            entry_valid  <= accept;
            rf_we        <= accept;
            flush_flags  <= accept;
            resv_clr     <= accept;
            mmu_busy     <= accept && (kind == EV_MMU);
        end
    end

    // Sticky nested-fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            double_fault <= 1'b0;
        else if (dfault_hit)
            double_fault <= 1'b1;
    end

    // Architectural register updates, committed together on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc     <= '0;
            rf_waddr   <= '0;
            rf_wdata   <= '0;
            status_out <= '0;
            esr_out    <= '0;
            ear_out    <= '0;
            btr_out    <= '0;
        end else if (accept) begin
            new_pc     <= vec_pc;
            rf_waddr   <= ra_idx;
            rf_wdata   <= ra_val;
            status_out <= status_nxt;
            esr_out    <= esr_nxt;
            ear_out    <= ear_nxt;
            btr_out    <= btr_nxt;
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
// Checker for the exception entry controller, bound to every instance.
// Assumes the bound names match the top module ports.
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_kind,
    input logic [XLEN-1:0] status_in,
    input logic            entry_valid,
    input logic            rf_we,
    input logic [XLEN-1:0] status_out,
    input logic [XLEN-1:0] esr_out,
    input logic [XLEN-1:0] ear_out,
    input logic            double_fault
);
    AST_NO_ENTRY_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_valid) |-> $past(req_valid)); // R13

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2 && !status_in[ST_IE]) |=> !entry_valid); // R5

    AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> (!status_out[ST_UM] && !status_out[ST_VM])); // R3

    AST_IRQ_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> (!entry_valid || !status_out[ST_IE])); // R4

    AST_WE_WITH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> entry_valid); // R2

    AST_DFAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        double_fault |=> double_fault); // R12

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_valid |-> ($stable(esr_out) && $stable(ear_out) && $stable(status_out))); // R13
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .status_in   (status_in),
    .entry_valid (entry_valid),
    .rf_we       (rf_we),
    .status_out  (status_out),
    .esr_out     (esr_out),
    .ear_out     (ear_out),
    .double_fault(double_fault)
);

// File: tb/test_exc_entry_ctrl.sv
// Directed bench for the exception entry controller.
module test_exc_entry_ctrl;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] cur_pc = '0, br_target = '0, status_in = '0, fault_addr = '0;
    logic        in_dslot = 1'b0, in_imm = 1'b0, br_was_imm = 1'b0, fault_miss = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [4:0]  hw_cause = '0;

    logic        entry_valid, rf_we, flush_flags, resv_clr, double_fault;
    logic [31:0] new_pc, rf_wdata, status_out, esr_out, ear_out, btr_out;
    logic [4:0]  rf_waddr;

    logic        n_entry_valid, n_rf_we, n_flush, n_resv, n_df;
    logic [31:0] n_new_pc, n_wdata, n_status, n_esr, n_ear, n_btr;
    logic [4:0]  n_waddr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl #(.VEC_BASE(BASE)) i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .cur_pc(cur_pc), .br_target(br_target), .in_dslot(in_dslot), .in_imm(in_imm),
        .br_was_imm(br_was_imm), .status_in(status_in), .acc_kind(acc_kind),
        .fault_miss(fault_miss), .fault_addr(fault_addr), .hw_cause(hw_cause),
        .entry_valid(entry_valid), .new_pc(new_pc), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .status_out(status_out), .esr_out(esr_out), .ear_out(ear_out),
        .btr_out(btr_out), .flush_flags(flush_flags), .resv_clr(resv_clr),
        .double_fault(double_fault)
    );

    exc_entry_ctrl #(.VEC_BASE(BASE), .EXC_EN(1'b0)) i_exc_entry_ctrl_noexc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .cur_pc(cur_pc), .br_target(br_target), .in_dslot(in_dslot), .in_imm(in_imm),
        .br_was_imm(br_was_imm), .status_in(status_in), .acc_kind(acc_kind),
        .fault_miss(fault_miss), .fault_addr(fault_addr), .hw_cause(hw_cause),
        .entry_valid(n_entry_valid), .new_pc(n_new_pc), .rf_we(n_rf_we), .rf_waddr(n_waddr),
        .rf_wdata(n_wdata), .status_out(n_status), .esr_out(n_esr), .ear_out(n_ear),
        .btr_out(n_btr), .flush_flags(n_flush), .resv_clr(n_resv),
        .double_fault(n_df)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Hold the request across one rising edge, then drop it; results are visible now.
    task automatic fire(input logic [1:0] kind);
        req_kind  = kind;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic clear_flags();
        in_dslot = 0; in_imm = 0; br_was_imm = 0;
    endtask

    task automatic t_reset();
        chk("R13 reset entry", {31'b0, entry_valid}, 32'd0);
        chk("R13 reset status", status_out, 32'd0);
        chk("R12 reset dfault", {31'b0, double_fault}, 32'd0);
    endtask

    task automatic t_irq();
        clear_flags();
        cur_pc = 32'h1000_0100; status_in = 32'h0000_4802;
        fire(2'd2);
        chk("R1 irq vector", new_pc, BASE + 32'h10);
        chk("R2 irq reg", {27'b0, rf_waddr}, 32'd14);
        chk("R2 irq ret", rf_wdata, 32'h1000_0100);
        chk("R3 R4 irq status", status_out, 32'h0000_1000);
        chk("R11 flush", {30'b0, flush_flags, resv_clr}, 32'd3);
        @(negedge clk);
        chk("R11 flush one cycle", {30'b0, flush_flags, resv_clr}, 32'd0);
    endtask

    task automatic t_irq_blocked();
        logic [31:0] st0;
        st0 = status_out;
        cur_pc = 32'h1000_0200;
        status_in = 32'h0; clear_flags(); fire(2'd2);
        chk("R5 irq ie off", {31'b0, entry_valid}, 32'd0);
        status_in = 32'h202; fire(2'd2);
        chk("R5 irq eip", {31'b0, entry_valid}, 32'd0);
        status_in = 32'h00a; fire(2'd2);
        chk("R5 irq bip", {31'b0, entry_valid}, 32'd0);
        status_in = 32'h2; in_dslot = 1; fire(2'd2);
        chk("R5 irq dslot", {31'b0, entry_valid}, 32'd0);
        in_dslot = 0; in_imm = 1; fire(2'd2);
        chk("R5 irq imm", {31'b0, entry_valid}, 32'd0);
        chk("R5 status untouched", status_out, st0);
        clear_flags();
    endtask

    task automatic t_break();
        clear_flags();
        cur_pc = 32'h2000_0040; status_in = 32'h0000_2800;
        fire(2'd3);
        chk("R1 brk vector", new_pc, BASE + 32'h18);
        chk("R2 brk reg", {27'b0, rf_waddr}, 32'd16);
        chk("R2 brk ret", rf_wdata, 32'h2000_0040);
        chk("R3 R4 brk status", status_out, 32'h0000_5008);
    endtask

    task automatic t_hwexc();
        clear_flags();
        cur_pc = 32'h3000_0000; status_in = 32'h2; hw_cause = 5'd1;
        fault_addr = 32'hdead_0001; br_target = 32'h3333_0000;
        fire(2'd0);
        chk("R1 hw vector", new_pc, BASE + 32'h20);
        chk("R2 hw reg", {27'b0, rf_waddr}, 32'd17);
        chk("R6 hw ret", rf_wdata, 32'h3000_0004);
        chk("R6 hw esr", esr_out, 32'h1);
        chk("R6 hw ear", ear_out, 32'hdead_0001);
        chk("R4 hw status", status_out, 32'h202);
        chk("R7 btr held", btr_out, 32'h0);
        in_dslot = 1; br_target = 32'h3333_0010;
        fire(2'd0);
        chk("R7 hw dslot esr", esr_out, 32'h1001);
        chk("R7 hw dslot btr", btr_out, 32'h3333_0010);
        clear_flags();
    endtask

    task automatic t_mmu();
        clear_flags();
        status_in = 32'h800; cur_pc = 32'h5000_0100; fault_addr = 32'h0bad_0000;
        acc_kind = 2'd2; fault_miss = 1; in_imm = 1;
        fire(2'd1);
        chk("R9 dstore miss esr", esr_out, 32'h412);
        chk("R8 imm ret", rf_wdata, 32'h5000_00fc);
        chk("R9 ear", ear_out, 32'h0bad_0000);
        chk("R4 mmu status", status_out, 32'h1200);
        @(negedge clk);
        clear_flags(); acc_kind = 2'd0; fault_miss = 0; in_dslot = 1; br_was_imm = 1;
        br_target = 32'h6000_0000;
        fire(2'd1);
        chk("R9 fetch prot esr", esr_out, 32'h1011);
        chk("R8 dslot bimm ret", rf_wdata, 32'h5000_00f8);
        chk("R7 mmu btr", btr_out, 32'h6000_0000);
        @(negedge clk);
        clear_flags(); acc_kind = 2'd1;
        fire(2'd1);
        chk("R9 dload prot esr", esr_out, 32'h10);
        chk("R8 plain ret", rf_wdata, 32'h5000_0100);
        @(negedge clk);
        in_dslot = 1; acc_kind = 2'd0; fault_miss = 1;
        fire(2'd1);
        chk("R9 fetch miss esr", esr_out, 32'h1013);
        chk("R8 dslot ret", rf_wdata, 32'h5000_00fc);
        clear_flags();
        @(negedge clk);
    endtask

    task automatic t_idle_hold();
        logic [31:0] e0, a0, s0;
        e0 = esr_out; a0 = ear_out; s0 = status_out;
        fault_addr = 32'h7777_7777; status_in = 32'hffff_ffff;
        repeat (3) @(negedge clk);
        chk("R13 idle esr", esr_out, e0);
        chk("R13 idle ear", ear_out, a0);
        chk("R13 idle status", status_out, s0);
        chk("R13 idle entry", {31'b0, entry_valid}, 32'd0);
    endtask

    task automatic t_double_fault();
        logic [31:0] w0;
        clear_flags(); status_in = 32'h0; cur_pc = 32'h8000_0000; acc_kind = 2'd1;
        req_kind = 2'd1; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R12 first fault entered", {31'b0, entry_valid}, 32'd1);
        w0 = rf_wdata;
        cur_pc = 32'h8000_0040;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R12 no reentry", {31'b0, entry_valid}, 32'd0);
        chk("R12 ret kept", rf_wdata, w0);
        chk("R12 dfault set", {31'b0, double_fault}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R12 dfault sticky", {31'b0, double_fault}, 32'd1);
    endtask

    task automatic t_noexc();
        logic [31:0] e0;
        e0 = n_esr;
        clear_flags(); hw_cause = 5'd7; fault_addr = 32'h1234_5678;
        fire(2'd0);
        chk("R10 disabled no entry", {31'b0, n_entry_valid}, 32'd0);
        chk("R10 disabled esr kept", n_esr, e0);
        chk("R10 enabled instance entered", {31'b0, entry_valid}, 32'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_irq();
        t_irq_blocked();
        t_break();
        t_hwexc();
        t_mmu();
        t_idle_hold();
        t_noexc();
        t_double_fault();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule